// File: doc/BRIEF.md
# Time-Multiplexed Multi-Port RAM

This block gives a set of logical write ports and read ports the view of one memory that they can all use in every system cycle. It does this with a single physical true dual-port array clocked a fixed factor (the pump factor) faster than the system rate. Every port request is registered on the fast edge that starts a system cycle. The requests are then sent to the two physical ports one fast sub-cycle at a time, in a fixed schedule. Each port of the array can read or write in any sub-cycle.

The schedule places every write in a sub-cycle before any read. Writes go two per sub-cycle in ascending port order, and reads follow the same pattern. A read therefore sees the writes of its own system cycle. When two writes of one cycle target the same word, the higher-numbered write port decides the stored value. All read results are updated together in one output register bank and hold their value until the next update.

Everything runs on the fast clock. A strobe input marks the fast cycle that begins each system cycle, and it must recur exactly every PUMP fast cycles. The system rate that can be reached is the array's clock rate divided by PUMP. The schedule needs ceil(NW/2)+ceil(NR/2) ≤ PUMP, and DEPTH must be a power of two.

Top module: `mpump_ram`

## Requirements
- R1: While reset is asserted and after it is released, before the first result, every rd_data lane reads 0 and every rd_valid bit is 0.
- R2: A word written in one system cycle is returned by a read of its address in any later system cycle, on any read port.
- R3: A read and a write to the same address in the same system cycle return the newly written data, because every write is performed before any read.
- R4: When several write ports target one address in the same system cycle, the data of the highest-numbered write port is stored.
- R5: The results of one system cycle appear on all read ports together, on the fast edge after the next strobe edge (PUMP+1 fast cycles after capture). rd_valid[j] then equals the rd_en[j] that was captured.
- R6: rd_data and rd_valid do not change on any fast edge other than the result edge of R5.
- R7: A read port whose rd_en was 0 in a system cycle returns rd_valid 0, and its rd_data lane holds the value it showed before.
- R8: A write port whose wr_en was 0 in a system cycle leaves memory unchanged, whatever its address and data.
- R9: Port inputs are sampled only on the strobe edge. Their values on all other fast edges have no effect.
- R10: sys_strobe is asserted on exactly one fast cycle in every PUMP, and the schedule relies on that spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (memory) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_strobe | input | 1 | High for the fast cycle whose closing edge starts a system cycle |
| wr_en | input | NW | Write request per write port |
| wr_addr | input | NW*AW | Write addresses, port k at bits [k*AW +: AW] |
| wr_data | input | NW*DW | Write data, port k at bits [k*DW +: DW] |
| rd_en | input | NR | Read request per read port |
| rd_addr | input | NR*AW | Read addresses, port j at bits [j*AW +: AW] |
| rd_data | output | NR*DW | Read results, port j at bits [j*DW +: DW] |
| rd_valid | output | NR | Port j returned a result for the last completed cycle |

## Verification
A sequencer out of step with the strobe shifts the sub-cycles, so a read moves ahead of a write. At the result edge of that same system cycle the port shows stale data, not the word written alongside it. A result register that is published one edge early or late, or in pieces, is seen by sampling both read ports on the exact result edge and again one fast cycle earlier. A mistake in the collision order or the write masking leaves a wrong word in the array. That word appears at the next read of the address, which the sweeps schedule in the same system cycle or the one after.

// File: rtl/mpram_pkg.sv
package mpram_pkg;

  // Index width for a count of n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Sub-cycles consumed when two physical ports serve n requests.
  function automatic int pair_slots(input int n);
    return (n + 1) / 2;
  endfunction

endpackage

// File: rtl/mpram_capture.sv
module mpram_capture #(
  parameter int NW = 2,
  parameter int NR = 2,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_strobe,
  input  logic [NW-1:0]    wr_en_i,
  input  logic [NW*AW-1:0] wr_addr_i,
  input  logic [NW*DW-1:0] wr_data_i,
  input  logic [NR-1:0]    rd_en_i,
  input  logic [NR*AW-1:0] rd_addr_i,
  output logic [NW-1:0]    cap_wr_en,
  output logic [NW*AW-1:0] cap_wr_addr,
  output logic [NW*DW-1:0] cap_wr_data,
  output logic [NR-1:0]    cap_rd_en,
  output logic [NR*AW-1:0] cap_rd_addr
);

  logic [NW-1:0]    wen_d,   wen_q;
  logic [NW*AW-1:0] wadr_d,  wadr_q;
  logic [NW*DW-1:0] wdat_d,  wdat_q;
  logic [NR-1:0]    ren_d,   ren_q;
  logic [NR*AW-1:0] radr_d,  radr_q;

  // Load enable is the strobe: requests are frozen for a whole system cycle.
  always_comb begin
    wen_d  = wen_q;
    wadr_d = wadr_q;
    wdat_d = wdat_q;
    ren_d  = ren_q;
    radr_d = radr_q;
    if (sys_strobe) begin
      wen_d  = wr_en_i;
      wadr_d = wr_addr_i;
      wdat_d = wr_data_i;
      ren_d  = rd_en_i;
      radr_d = rd_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q  <= '0;
      wadr_q <= '0;
      wdat_q <= '0;
      ren_q  <= '0;
      radr_q <= '0;
    end else begin
      wen_q  <= wen_d;
      wadr_q <= wadr_d;
      wdat_q <= wdat_d;
      ren_q  <= ren_d;
      radr_q <= radr_d;
    end
  end

  assign cap_wr_en   = wen_q;
  assign cap_wr_addr = wadr_q;
  assign cap_wr_data = wdat_q;
  assign cap_rd_en   = ren_q;
  assign cap_rd_addr = radr_q;

endmodule

// File: rtl/mpram_sequencer.sv
module mpram_sequencer
  import mpram_pkg::*;
#(
  parameter int NW   = 2,
  parameter int NR   = 2,
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int PUMP = 2,
  parameter int RIW  = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sys_strobe,
  input  logic [NW-1:0]            cap_wr_en,
  input  logic [NW*AW-1:0]         cap_wr_addr,
  input  logic [NW*DW-1:0]         cap_wr_data,
  input  logic [NR-1:0]            cap_rd_en,
  input  logic [NR*AW-1:0]         cap_rd_addr,
  output logic [1:0]               phy_we,
  output logic [1:0]               phy_re,
  output logic [1:0][AW-1:0]       phy_addr,
  output logic [1:0][DW-1:0]       phy_wd,
  output logic [1:0]               tag_vld,
  output logic [1:0][RIW-1:0]      tag_idx,
  output logic                     pub
);

  localparam int PW  = idx_w(PUMP);
  localparam int NWS = pair_slots(NW);
  localparam logic [PW-1:0] PH_LAST = PW'(PUMP - 1);

  logic [PW-1:0]        phase_d, phase_q;
  logic                 run_d, run_q;
  logic                 rseen_d, rseen_q;
  logic                 last_d, last_q;
  logic [1:0]           tvld_d, tvld_q;
  logic [1:0][RIW-1:0]  tidx_d, tidx_q;
  logic [1:0][RIW-1:0]  ridx;
  int                   ph;

  // Phase counter: restarts on the strobe, parks on the last sub-cycle.
  always_comb begin
    phase_d = phase_q;
    if (sys_strobe)              phase_d = '0;
    else if (phase_q != PH_LAST) phase_d = phase_q + PW'(1);
    run_d   = run_q | sys_strobe;
    ph      = int'(phase_q);
  end

  // Static schedule: write k on phys port k%2 in slot k/2,
  // read k on phys port k%2 in slot NWS + k/2.
  always_comb begin
    phy_we   = '0;
    phy_re   = '0;
    phy_addr = '0;
    phy_wd   = '0;
    ridx     = '0;
    if (run_q) begin
      for (int p = 0; p < 2; p++) begin
        for (int k = 0; k < NW; k++) begin
          if ((k % 2) == p && (k / 2) == ph) begin
            phy_we[p]   = cap_wr_en[k];
            phy_addr[p] = cap_wr_addr[k*AW +: AW];
            phy_wd[p]   = cap_wr_data[k*DW +: DW];
          end
        end
        for (int k = 0; k < NR; k++) begin
          if ((k % 2) == p && (NWS + k / 2) == ph) begin
            phy_re[p]   = cap_rd_en[k];
            phy_addr[p] = cap_rd_addr[k*AW +: AW];
            ridx[p]     = RIW'(k);
          end
        end
      end
    end
  end

  always_comb begin
    tvld_d  = phy_re;
    tidx_d  = ridx;
    last_d  = run_q && (phase_q == PH_LAST);
    rseen_d = sys_strobe ? 1'b0 : (rseen_q | (|phy_re));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LAST;
      run_q   <= 1'b0;
      rseen_q <= 1'b0;
      last_q  <= 1'b0;
      tvld_q  <= '0;
      tidx_q  <= '0;
    end else begin
      phase_q <= phase_d;
      run_q   <= run_d;
      rseen_q <= rseen_d;
      last_q  <= last_d;
      tvld_q  <= tvld_d;
      tidx_q  <= tidx_d;
    end
  end

  assign tag_vld = tvld_q;
  assign tag_idx = tidx_q;
  assign pub     = last_q;

  AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (sys_strobe == (phase_q == PH_LAST))); // R10

  AST_WRITES_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (|phy_we) |-> !rseen_q); // R3

endmodule

// File: rtl/mpram_tdp_array.sv
module mpram_tdp_array #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          we,
  input  logic [1:0]          re,
  input  logic [1:0][AW-1:0]  addr,
  input  logic [1:0][DW-1:0]  wd,
  output logic [1:0][DW-1:0]  q
);

  logic [DW-1:0]       mem [DEPTH];
  logic [1:0][DW-1:0]  q_d, q_q;

  // Port 1 is written after port 0, so it wins a same-address collision.
  always_ff @(posedge clk) begin
    if (we[0]) mem[addr[0]] <= wd[0];
    if (we[1]) mem[addr[1]] <= wd[1];
  end

  always_comb begin
    q_d = q_q;
    for (int p = 0; p < 2; p++) begin
      if (re[p]) q_d[p] = mem[addr[p]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  AST_NO_MIXED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|we) |-> !(|re)); // R3

endmodule

// File: rtl/mpram_collect.sv
module mpram_collect #(
  parameter int NR  = 2,
  parameter int DW  = 8,
  parameter int RIW = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pub,
  input  logic [1:0][DW-1:0]  q,
  input  logic [1:0]          tag_vld,
  input  logic [1:0][RIW-1:0] tag_idx,
  output logic [NR*DW-1:0]    rd_data,
  output logic [NR-1:0]       rd_valid
);

  logic [NR-1:0][DW-1:0] stg_d, stg_q, out_d, out_q;
  logic [NR-1:0]         svld_d, svld_q, ovld_d, ovld_q;
  logic [NR-1:0]         hit;
  logic [NR-1:0][DW-1:0] hq;

  // Steer each returning word to its logical port; the last slot bypasses
  // the staging bank so every port publishes on the same edge.
  always_comb begin
    for (int j = 0; j < NR; j++) begin
      hit[j] = 1'b0;
      hq[j]  = '0;
      for (int p = 0; p < 2; p++) begin
        if (tag_vld[p] && tag_idx[p] == RIW'(j)) begin
          hit[j] = 1'b1;
          hq[j]  = q[p];
        end
      end
      stg_d[j]  = hit[j] ? hq[j] : stg_q[j];
      svld_d[j] = pub ? 1'b0 : (svld_q[j] | hit[j]);
      out_d[j]  = pub ? (hit[j] ? hq[j] : stg_q[j]) : out_q[j];
      ovld_d[j] = pub ? (svld_q[j] | hit[j]) : ovld_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      svld_q <= '0;
      out_q  <= '0;
      ovld_q <= '0;
    end else begin
      stg_q  <= stg_d;
      svld_q <= svld_d;
      out_q  <= out_d;
      ovld_q <= ovld_d;
    end
  end

  assign rd_data  = out_q;
  assign rd_valid = ovld_q;

  AST_PUB_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    pub |=> !pub); // R5

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (&tag_vld) |-> (tag_idx[0] != tag_idx[1])); // R5

endmodule

// File: rtl/mpump_ram.sv
module mpump_ram
  import mpram_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int NW    = 2,
  parameter int NR    = 2,
  parameter int PUMP  = 2,
  localparam int AW   = idx_w(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_strobe,
  input  logic [NW-1:0]    wr_en,
  input  logic [NW*AW-1:0] wr_addr,
  input  logic [NW*DW-1:0] wr_data,
  input  logic [NR-1:0]    rd_en,
  input  logic [NR*AW-1:0] rd_addr,
  output logic [NR*DW-1:0] rd_data,
  output logic [NR-1:0]    rd_valid
);

  localparam int RIW = idx_w(NR);

  logic [NW-1:0]        c_wen;
  logic [NW*AW-1:0]     c_wadr;
  logic [NW*DW-1:0]     c_wdat;
  logic [NR-1:0]        c_ren;
  logic [NR*AW-1:0]     c_radr;
  logic [1:0]           p_we, p_re, t_vld;
  logic [1:0][AW-1:0]   p_addr;
  logic [1:0][DW-1:0]   p_wd, p_q;
  logic [1:0][RIW-1:0]  t_idx;
  logic                 pub;

  mpram_capture #(.NW(NW), .NR(NR), .AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .sys_strobe(sys_strobe),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .cap_wr_en(c_wen), .cap_wr_addr(c_wadr), .cap_wr_data(c_wdat),
    .cap_rd_en(c_ren), .cap_rd_addr(c_radr)
  );

  mpram_sequencer #(.NW(NW), .NR(NR), .AW(AW), .DW(DW), .PUMP(PUMP), .RIW(RIW)) u_seq (
    .clk(clk), .rst_n(rst_n), .sys_strobe(sys_strobe),
    .cap_wr_en(c_wen), .cap_wr_addr(c_wadr), .cap_wr_data(c_wdat),
    .cap_rd_en(c_ren), .cap_rd_addr(c_radr),
    .phy_we(p_we), .phy_re(p_re), .phy_addr(p_addr), .phy_wd(p_wd),
    .tag_vld(t_vld), .tag_idx(t_idx), .pub(pub)
  );

  mpram_tdp_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(p_we), .re(p_re),
    .addr(p_addr), .wd(p_wd), .q(p_q)
  );

  mpram_collect #(.NR(NR), .DW(DW), .RIW(RIW)) u_col (
    .clk(clk), .rst_n(rst_n), .pub(pub), .q(p_q),
    .tag_vld(t_vld), .tag_idx(t_idx),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: tb/mpump_ram_tb.sv
module mpump_ram_tb;

  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int NW    = 2;
  localparam int NR    = 2;
  localparam int PUMP  = 2;
  localparam int AW    = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sys_strobe;
  logic [NW-1:0]    wr_en;
  logic [NW*AW-1:0] wr_addr;
  logic [NW*DW-1:0] wr_data;
  logic [NR-1:0]    rd_en;
  logic [NR*AW-1:0] rd_addr;
  logic [NR*DW-1:0] rd_data;
  logic [NR-1:0]    rd_valid;

  mpump_ram #(.DEPTH(DEPTH), .DW(DW), .NW(NW), .NR(NR), .PUMP(PUMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sys_strobe(sys_strobe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [DW-1:0] mref [DEPTH];
  logic [DW-1:0] cur_d  [NR];
  logic [DW-1:0] held_d [NR];
  logic          held_v [NR];
  logic [DW-1:0] pend_d [NR];
  logic          pend_v [NR];
  string         pend_t [NR];
  bit            pend = 0;

  task automatic chk(input string tag, input int j,
                     input logic [DW-1:0] gd, input logic [DW-1:0] ed,
                     input logic gv, input logic ev);
    total++;
    if (gd !== ed || gv !== ev) begin
      bad++;
      $display("FAIL %s port%0d data=%h exp=%h valid=%b exp=%b", tag, j, gd, ed, gv, ev);
    end
  endtask

  // R9: junk on every non-strobe cycle must not be sampled.
  task automatic scramble();
    lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_en   = lfsr[1:0] | 2'b01;
    wr_addr = lfsr[7:0];
    wr_data = {lfsr[7:0], lfsr[15:8]};
    rd_en   = lfsr[3:2];
    rd_addr = lfsr[11:4];
  endtask

  // One system cycle; entered and left at the negedge before a strobe edge.
  // Strobe recurs every PUMP fast cycles (R10).
  task automatic sys_cycle(input logic [1:0] we, input int wa0, input int wa1,
                           input int wd0, input int wd1,
                           input logic [1:0] re, input int ra0, input int ra1,
                           input string t0, input string t1);
    logic [DW-1:0] nd [NR];
    sys_strobe = 1'b1;
    wr_en   = we;
    wr_addr = {AW'(wa1), AW'(wa0)};
    wr_data = {DW'(wd1), DW'(wd0)};
    rd_en   = re;
    rd_addr = {AW'(ra1), AW'(ra0)};
    if (we[0]) mref[wa0] = DW'(wd0);
    if (we[1]) mref[wa1] = DW'(wd1);
    if (re[0]) cur_d[0] = mref[ra0];
    if (re[1]) cur_d[1] = mref[ra1];
    nd = cur_d;
    @(posedge clk);
    @(negedge clk);
    sys_strobe = 1'b0;
    scramble();
    for (int j = 0; j < NR; j++)
      chk("R6", j, rd_data[j*DW +: DW], held_d[j], rd_valid[j], held_v[j]);
    @(posedge clk);
    @(negedge clk);
    if (pend) begin
      for (int j = 0; j < NR; j++) begin
        chk(pend_t[j], j, rd_data[j*DW +: DW], pend_d[j], rd_valid[j], pend_v[j]);
        held_d[j] = pend_d[j];
        held_v[j] = pend_v[j];
      end
    end
    pend_d = nd;
    pend_v[0] = re[0];
    pend_v[1] = re[1];
    pend_t[0] = re[0] ? t0 : "R7";
    pend_t[1] = re[1] ? t1 : "R7";
    pend = 1;
    repeat (PUMP - 2) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sys_strobe = 1'b0;
    wr_en = '0; wr_addr = '0; wr_data = '0; rd_en = '0; rd_addr = '0;
    for (int j = 0; j < NR; j++) begin
      cur_d[j] = '0; held_d[j] = '0; held_v[j] = 1'b0;
    end
    repeat (3) @(negedge clk);
    for (int j = 0; j < NR; j++)
      chk("R1", j, rd_data[j*DW +: DW], '0, rd_valid[j], 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int j = 0; j < NR; j++)
      chk("R1", j, rd_data[j*DW +: DW], '0, rd_valid[j], 1'b0);

    // Fill every word, reads off (R7 on both ports).
    for (int a = 0; a < DEPTH; a += 2)
      sys_cycle(2'b11, a, a + 1, (a * 29 + 3) & 255, (a * 41 + 100) & 255,
                2'b00, 0, 0, "R7", "R7");
    // R2: read back in later cycles, swapped ports, both results together (R5).
    for (int a = 0; a < DEPTH; a += 2)
      sys_cycle(2'b00, 0, 0, 0, 0, 2'b11, a, a + 1, "R2", "R2");
    for (int a = 0; a < DEPTH; a += 2)
      sys_cycle(2'b00, 0, 0, 0, 0, 2'b11, a + 1, a, "R5", "R5");
    // R4: both write ports on one address; read it back the same cycle.
    for (int a = 0; a < DEPTH; a++)
      sys_cycle(2'b11, a, a, (a * 7 + 1) & 255, (a * 13 + 200) & 255,
                2'b11, a, a, "R4", "R4");
    // R3: write on port 0 read by port 1 in the same cycle.
    for (int a = 0; a < DEPTH; a++)
      sys_cycle(2'b01, a, 0, (a * 53 + 9) & 255, 0,
                2'b11, (a + 5) % DEPTH, a, "R2", "R3");
    // R8: disabled writes carry live-looking addresses and data.
    for (int a = 0; a < DEPTH; a++)
      sys_cycle(2'b00, a, (a + 1) % DEPTH, 255, 170,
                2'b11, a, (a + 1) % DEPTH, "R8", "R8");
    // Full enable sweep with colliding addresses, junk between strobes (R9).
    for (int i = 0; i < 256; i++)
      sys_cycle(2'(i), (i * 5) % DEPTH, (i * 3 + 7) % DEPTH,
                (i * 31 + 5) & 255, (i * 17 + 77) & 255,
                2'(i >> 2), (i * 7 + 1) % DEPTH, (i * 5) % DEPTH, "R9", "R9");
    sys_cycle(2'b00, 0, 0, 0, 0, 2'b00, 0, 0, "R7", "R7");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule